// File: doc/BRIEF.md
# Command Queue Channel Controller

This block is the control plane of one storage channel that works through a 32-entry command queue held in host memory. Software programs the queue's base address and posts work by setting one bit per queue slot. The controller then picks pending slots one at a time and hands each to a command-execution engine. The engine does the memory fetches and data movement; the controller sees only a start/done/error handshake.

When the engine reports success, the controller clears that slot's pending bit and records a completion flag. When the engine reports a fault, the controller captures the failing slot and the failing buffer index. It then freezes the channel until software clears the status word. One interrupt line combines the completion and error flags under individual enables. Writing zero to the run register soft-resets the channel.

Top module: `cq_chan_ctrl`

## Requirements
- R1: A write to the slot-pending register (offset 0x14) ORs the write data into the held value and never clears a bit; with the channel stopped, posting 0x10 then 0x01 reads back 0x11.
- R2: When the engine signals done for slot s, pending bit s is cleared and status bit 0 is set. If a slot-pending write lands in the same cycle as a completion, the two updates merge: bits set by the write stay set, even the bit being cleared.
- R3: Any write to the status register (offset 0x08) clears all 32 bits, whatever the write data.
- R4: On an engine error the status register gets bit 30 set, bits 28:24 = failing slot and bits 23:8 = failing buffer index from the engine. The failed slot stays pending and no further command starts until software writes the status register. After that write, dispatch resumes.
- R5: `irq` is high exactly when (status bit 0 and enable bit 0) or (status bit 30 and enable bit 30).
- R6: The interrupt-enable register (offset 0x0C) stores only bits 0 and 30; other bits read as zero.
- R7: Writing a nonzero value to the run register (offset 0x10) sets it, and it reads as 1. Writing zero clears the slot-pending, status, interrupt-enable and run registers and abandons any command in progress. The base-address registers are kept.
- R8: The list base low register (offset 0x00) forces bits 3:0 to zero. The high register (offset 0x04) holds all 32 bits. `list_base` presents {high, low}.
- R9: Pending slots are dispatched round-robin, searching upward from the slot after the last one completed with wrap at 31. After reset or a run-zero write, the search starts at slot 0.
- R10: `eng_start` is a one-cycle pulse carrying the slot on `eng_slot`. No second start is issued until the engine has answered the first.
- R11: Reads of offsets other than the six mapped ones return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| list_base | output | 64 | Command-queue base address |
| eng_start | output | 1 | Start pulse to the execution engine |
| eng_slot | output | 5 | Slot index of the started command |
| eng_done | input | 1 | Engine reports success |
| eng_err | input | 1 | Engine reports a fault |
| eng_err_buf | input | 16 | Index of the faulty buffer, valid with eng_err |
| irq | output | 1 | Channel interrupt |

## Verification
The hazardous coincidence is an engine completion and a software post to the slot-pending register in the same clock. The bench counts engine cycles after a start, so that the post of that same slot plus one new slot lands exactly on the done pulse. A scoreboard of expected start order then has to see the re-posted slot dispatched again after the new one, and the register must end empty. A second overlap is tested as well: a software run-zero write arrives in the cycle where the dispatcher would pick a freshly posted slot, and no start may appear.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int NSLOT  = 32;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int BUF_W  = 16;

    localparam logic [7:0] OFF_BASE_LO = 8'h00;
    localparam logic [7:0] OFF_BASE_HI = 8'h04;
    localparam logic [7:0] OFF_STATUS  = 8'h08;
    localparam logic [7:0] OFF_IE      = 8'h0C;
    localparam logic [7:0] OFF_RUN     = 8'h10;
    localparam logic [7:0] OFF_PEND    = 8'h14;

    localparam int ST_DONE_BIT = 0;
    localparam int ST_ERR_BIT  = 30;
    localparam int ST_SLOT_LSB = 24;
    localparam int ST_BUF_LSB  = 8;

    localparam logic [DATA_W-1:0] IE_MASK   = (DATA_W'(1) << ST_ERR_BIT) | (DATA_W'(1) << ST_DONE_BIT);
    localparam logic [DATA_W-1:0] ALIGN_MSK = ~DATA_W'(32'hF);

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ISSUE,
        CH_BUSY,
        CH_HALT
    } ch_state_e;

    typedef struct packed {
        logic              done;
        logic              err;
        logic [SLOT_W-1:0] slot;
        logic [BUF_W-1:0]  buf_idx;
    } hw_evt_t;

    function automatic logic [DATA_W-1:0] err_word(input logic [SLOT_W-1:0] slot,
                                                   input logic [BUF_W-1:0]  bidx);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_ERR_BIT] = 1'b1;
        w[ST_SLOT_LSB +: SLOT_W] = slot;
        w[ST_BUF_LSB +: BUF_W]   = bidx;
        return w;
    endfunction
endpackage

// File: rtl/cq_rr_pick.sv
module cq_rr_pick #(
    parameter int N  = cq_pkg::NSLOT,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] last,
    output logic          any,
    output logic [SW-1:0] grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(last) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                grant = SW'(idx);
                found = 1'b1;
            end
        end
        any = |req;
    end

    always_comb begin
        if (any) assert_grant_pending_R9: assert (req[grant]);
    end
endmodule

// File: rtl/cq_chan_fsm.sv
module cq_chan_fsm
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              soft_rst,
    input  logic              stat_wr,
    input  logic              pend_any,
    input  logic [SLOT_W-1:0] pick_slot,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [BUF_W-1:0]  eng_err_buf,
    output logic              eng_start,
    output logic [SLOT_W-1:0] eng_slot,
    output logic [SLOT_W-1:0] last_slot,
    output hw_evt_t           evt
);
    ch_state_e         state_q, state_d;
    logic [SLOT_W-1:0] cur_q, cur_d;
    logic [SLOT_W-1:0] last_q, last_d;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        last_d  = last_q;
        if (soft_rst) begin
            state_d = CH_IDLE;
            last_d  = SLOT_W'(NSLOT - 1);
        end else begin
            unique case (state_q)
                CH_IDLE: if (run && pend_any) begin
                    cur_d   = pick_slot;
                    state_d = CH_ISSUE;
                end
                CH_ISSUE: state_d = CH_BUSY;
                CH_BUSY: begin
                    if (eng_err) state_d = CH_HALT;
                    else if (eng_done) begin
                        last_d  = cur_q;
                        state_d = CH_IDLE;
                    end
                end
                CH_HALT: if (stat_wr) state_d = CH_IDLE;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cur_q   <= '0;
            last_q  <= SLOT_W'(NSLOT - 1);
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        evt.done    = (state_q == CH_BUSY) && eng_done && !eng_err && !soft_rst;
        evt.err     = (state_q == CH_BUSY) && eng_err && !soft_rst;
        evt.slot    = cur_q;
        evt.buf_idx = eng_err_buf;
    end

    assign eng_start = (state_q == CH_ISSUE);
    assign eng_slot  = cur_q;
    assign last_slot = last_q;

    assert_single_flight_R10: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    assert_halt_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.err && !stat_wr) |=> (state_q == CH_HALT && !eng_start));
    assert_soft_rst_idle_R7: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (state_q == CH_IDLE && last_q == SLOT_W'(NSLOT - 1)));
endmodule

// File: rtl/cq_reg_bank.sv
module cq_reg_bank
    import cq_pkg::*;
#(
    parameter int AW = cq_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  hw_evt_t           evt,
    output logic [DATA_W-1:0] rdata,
    output logic [NSLOT-1:0]  pending,
    output logic              run,
    output logic [1:0]        st_flags,
    output logic [1:0]        ie_flags,
    output logic [2*DATA_W-1:0] base,
    output logic              soft_rst,
    output logic              stat_wr
);
    logic [DATA_W-1:0] base_lo_q, base_hi_q, status_q, ie_q;
    logic [DATA_W-1:0] status_d;
    logic [NSLOT-1:0]  pend_q, pend_d, pend_set, pend_clr;
    logic              run_q;
    logic              wr_lo, wr_hi, wr_ie, wr_run, wr_pend;

    assign wr_lo   = we && (addr == AW'(OFF_BASE_LO));
    assign wr_hi   = we && (addr == AW'(OFF_BASE_HI));
    assign stat_wr = we && (addr == AW'(OFF_STATUS));
    assign wr_ie   = we && (addr == AW'(OFF_IE));
    assign wr_run  = we && (addr == AW'(OFF_RUN));
    assign wr_pend = we && (addr == AW'(OFF_PEND));
    assign soft_rst = wr_run && (wdata == '0);

    always_comb begin
        pend_set = wr_pend ? NSLOT'(wdata) : '0;
        pend_clr = evt.done ? (NSLOT'(1) << evt.slot) : '0;
        pend_d   = soft_rst ? '0 : ((pend_q & ~pend_clr) | pend_set);
    end

    always_comb begin
        status_d = stat_wr ? '0 : status_q;
        if (evt.done) status_d[ST_DONE_BIT] = 1'b1;
        if (evt.err) begin
            status_d[ST_ERR_BIT] = 1'b1;
            status_d[ST_SLOT_LSB +: SLOT_W] = evt.slot;
            status_d[ST_BUF_LSB +: BUF_W]   = evt.buf_idx;
        end
        if (soft_rst) status_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            status_q  <= '0;
            ie_q      <= '0;
            run_q     <= 1'b0;
            pend_q    <= '0;
        end else begin
            if (wr_lo) base_lo_q <= wdata & ALIGN_MSK;
            if (wr_hi) base_hi_q <= wdata;
            status_q <= status_d;
            pend_q   <= pend_d;
            if (soft_rst) begin
                ie_q  <= '0;
                run_q <= 1'b0;
            end else begin
                if (wr_ie)  ie_q  <= wdata & IE_MASK;
                if (wr_run) run_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFF_BASE_LO))      rdata = base_lo_q;
        else if (addr == AW'(OFF_BASE_HI)) rdata = base_hi_q;
        else if (addr == AW'(OFF_STATUS))  rdata = status_q;
        else if (addr == AW'(OFF_IE))      rdata = ie_q;
        else if (addr == AW'(OFF_RUN))     rdata = DATA_W'(run_q);
        else if (addr == AW'(OFF_PEND))    rdata = DATA_W'(pend_q);
    end

    assign pending  = pend_q;
    assign run      = run_q;
    assign st_flags = {status_q[ST_ERR_BIT], status_q[ST_DONE_BIT]};
    assign ie_flags = {ie_q[ST_ERR_BIT], ie_q[ST_DONE_BIT]};
    assign base     = {base_hi_q, base_lo_q};

    assert_or_write_keeps_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && !soft_rst) |=> ((pend_q & $past(NSLOT'(wdata))) == $past(NSLOT'(wdata))));
    assert_done_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (evt.done && !soft_rst) |=> status_q[ST_DONE_BIT]);
    assert_status_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !evt.done && !evt.err) |=> (status_q == '0));
    assert_err_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.err && !soft_rst) |=> (status_q[ST_ERR_BIT] && status_q[ST_SLOT_LSB +: SLOT_W] == $past(evt.slot)));
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (pend_q == '0 && !run_q && ie_q == '0 && status_q == '0));
    assert_base_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        base_lo_q[3:0] == 4'h0);
endmodule

// File: rtl/cq_chan_ctrl.sv
module cq_chan_ctrl
    import cq_pkg::*;
#(
    parameter int ADDR_W = cq_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [2*DATA_W-1:0] list_base,
    output logic                eng_start,
    output logic [SLOT_W-1:0]   eng_slot,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [BUF_W-1:0]    eng_err_buf,
    output logic                irq
);
    logic [NSLOT-1:0]  pending;
    logic              run, soft_rst, stat_wr, pend_any;
    logic [1:0]        st_flags, ie_flags;
    logic [SLOT_W-1:0] pick_slot, last_slot;
    hw_evt_t           evt;
    logic              ie_wr;

    cq_reg_bank #(.AW(ADDR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .evt      (evt),
        .rdata    (reg_rdata),
        .pending  (pending),
        .run      (run),
        .st_flags (st_flags),
        .ie_flags (ie_flags),
        .base     (list_base),
        .soft_rst (soft_rst),
        .stat_wr  (stat_wr)
    );

    cq_rr_pick #(.N(NSLOT), .SW(SLOT_W)) u_pick (
        .req   (pending),
        .last  (last_slot),
        .any   (pend_any),
        .grant (pick_slot)
    );

    cq_chan_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .soft_rst    (soft_rst),
        .stat_wr     (stat_wr),
        .pend_any    (pend_any),
        .pick_slot   (pick_slot),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .eng_err_buf (eng_err_buf),
        .eng_start   (eng_start),
        .eng_slot    (eng_slot),
        .last_slot   (last_slot),
        .evt         (evt)
    );

    assign irq   = |(st_flags & ie_flags);
    assign ie_wr = reg_we && (reg_addr == ADDR_W'(OFF_IE));

    assert_err_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.err && ie_flags[1] && !soft_rst && !ie_wr) |=> irq);
    assert_start_pending_R10: assert property (@(posedge clk) disable iff (rst)
        (eng_start && !soft_rst) |-> pending[eng_slot]);
endmodule

// File: tb/cq_chan_ctrl_test.sv
`timescale 1ns/1ps
module cq_chan_ctrl_test;
    import cq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] list_base;
    logic        eng_start;
    logic [4:0]  eng_slot;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [15:0] eng_err_buf = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    int start_cnt = 0;
    int err_slot = -1;
    localparam int LAT = 3;

    always #2.5 clk = ~clk;

    cq_chan_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .list_base(list_base),
        .eng_start(eng_start), .eng_slot(eng_slot), .eng_done(eng_done),
        .eng_err(eng_err), .eng_err_buf(eng_err_buf), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
    endtask

    // engine model and start-order scoreboard monitor
    initial begin
        int cnt = 0;
        int cur = 0;
        bit resp = 0;
        bit prev = 0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_err  = 1'b0;
            if (resp) begin
                if (cnt == 0) begin
                    if (cur == err_slot) begin
                        eng_err = 1'b1;
                        eng_err_buf = 16'h0ABC;
                    end else eng_done = 1'b1;
                    resp = 0;
                end else cnt--;
            end
            if (eng_start) begin
                start_cnt++;
                tests++;
                if (prev) begin
                    fails++;
                    $display("FAIL R10: start held two cycles got 1 expected 0");
                end
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9: unexpected start slot got %0d expected none", eng_slot);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(eng_slot) != e) begin
                        fails++;
                        $display("FAIL R9: start slot got %0d expected %0d", eng_slot, e);
                    end
                end
                cur = int'(eng_slot);
                resp = 1;
                cnt = LAT - 1;
            end
            prev = eng_start;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int sc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd_check("R7 reset pend", 8'h14, 32'h0);
        rd_check("R7 reset status", 8'h08, 32'h0);
        rd_check("R7 reset ie", 8'h0C, 32'h0);
        rd_check("R7 reset run", 8'h10, 32'h0);
        rd_check("R8 reset base lo", 8'h00, 32'h0);
        check("R5 reset irq", irq, 0);
        check("R10 reset start", eng_start, 0);

        // base address
        wr(8'h00, 32'h1234_567F);
        wr(8'h04, 32'hDEAD_BEEF);
        rd_check("R8 base lo aligned", 8'h00, 32'h1234_5670);
        rd_check("R8 base hi", 8'h04, 32'hDEAD_BEEF);
        check("R8 list_base", list_base, 64'hDEAD_BEEF_1234_5670);

        // enables and unmapped
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check("R6 ie mask", 8'h0C, 32'h4000_0001);
        rd_check("R11 unmapped 0x18", 8'h18, 32'h0);
        rd_check("R11 unmapped 0x40", 8'h40, 32'h0);

        // OR-write while stopped
        wr(8'h14, 32'h10);
        wr(8'h14, 32'h01);
        rd_check("R1 or write", 8'h14, 32'h11);
        wr(8'h14, 32'hA0);
        rd_check("R1 or write 2", 8'h14, 32'hB1);
        check("R7 no start while stopped", start_cnt, 0);

        // start run: order from slot 0
        exp_q.push_back(0); exp_q.push_back(4); exp_q.push_back(5); exp_q.push_back(7);
        wr(8'h10, 32'h1);
        repeat (60) @(negedge clk);
        rd_check("R2 pend drained", 8'h14, 32'h0);
        rd_check("R2 done flag", 8'h08, 32'h1);
        rd_check("R7 run reads 1", 8'h10, 32'h1);
        check("R5 irq on done", irq, 1);
        check("R9 first batch dispatched", exp_q.size(), 0);

        // status clear on any write
        wr(8'h08, 32'h1234);
        rd_check("R3 status cleared", 8'h08, 32'h0);
        check("R5 irq low", irq, 0);

        // round robin wrap: last=7
        exp_q.push_back(8); exp_q.push_back(0); exp_q.push_back(1);
        wr(8'h14, 32'h103);
        repeat (60) @(negedge clk);
        rd_check("R9 wrap drained", 8'h14, 32'h0);
        check("R9 wrap order", exp_q.size(), 0);

        // completion and post in the same cycle
        exp_q.push_back(9);
        wr(8'h14, 32'h200);
        while (!eng_start) @(negedge clk);
        exp_q.push_back(3); exp_q.push_back(9);
        repeat (LAT) @(negedge clk);
        wr(8'h14, 32'h208);
        repeat (60) @(negedge clk);
        rd_check("R2 merge drained", 8'h14, 32'h0);
        check("R2 merge re-post kept", exp_q.size(), 0);

        // error capture and halt
        wr(8'h08, 32'h0);
        err_slot = 11;
        exp_q.push_back(10); exp_q.push_back(11);
        wr(8'h14, 32'hC00);
        repeat (60) @(negedge clk);
        rd_check("R4 error word", 8'h08, 32'h4B0A_BC01);
        rd_check("R4 failed slot pending", 8'h14, 32'h800);
        check("R5 irq on error", irq, 1);
        sc = start_cnt;
        wr(8'h14, 32'h1000);
        repeat (30) @(negedge clk);
        check("R4 halted no start", start_cnt, sc);
        rd_check("R4 pend while halted", 8'h14, 32'h1800);
        err_slot = -1;
        exp_q.push_back(11); exp_q.push_back(12);
        wr(8'h08, 32'hFFFF_FFFF);
        repeat (60) @(negedge clk);
        rd_check("R4 resumed status", 8'h08, 32'h1);
        rd_check("R4 resumed drained", 8'h14, 32'h0);
        check("R4 retry order", exp_q.size(), 0);

        // soft reset racing a fresh post
        sc = start_cnt;
        wr(8'h14, 32'hF0);
        wr(8'h10, 32'h0);
        repeat (20) @(negedge clk);
        check("R7 soft reset preempts dispatch", start_cnt, sc);
        rd_check("R7 pend cleared", 8'h14, 32'h0);
        rd_check("R7 status cleared", 8'h08, 32'h0);
        rd_check("R7 ie cleared", 8'h0C, 32'h0);
        rd_check("R7 run cleared", 8'h10, 32'h0);
        rd_check("R7 base kept", 8'h00, 32'h1234_5670);
        check("R7 irq low", irq, 0);
        wr(8'h10, 32'h5);
        rd_check("R7 run nonzero", 8'h10, 32'h1);
        repeat (10) @(negedge clk);
        check("R10 all expected starts seen", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule